// File: doc/BRIEF.md
# Block-Cipher DMA Job Sequencer

This block is the control front end of a block-cipher accelerator running in DMA mode. A trigger strobe starts a job. If the DMA-enable input is low, the block fires a one-cycle strobe to a separate single-block engine and does nothing else. If DMA is enabled, the block checks the operation mode and the chaining mode. A valid job latches its settings and runs a fixed sequence: it requests a stream read of the block count times 16 bytes, hands the data to an external cipher datapath, and requests a stream write of the same length. It then reports completion and, if enabled, raises an interrupt.

The sequencer has five states. IDLE waits for a trigger. READ holds the read request until the read stream reports done or an error. CRYPT holds the datapath go signal until the datapath reports done. WRITE holds the write request until the write stream reports done or an error. DONE holds the result until the DMA-exit strobe arrives or a new job starts.

The transitions are as follows:
- IDLE→READ and DONE→READ on a valid DMA trigger.
- READ→CRYPT on read done.
- READ→IDLE on read error.
- CRYPT→WRITE on datapath done.
- WRITE→DONE on write done.
- WRITE→IDLE on write error.
- DONE→IDLE on DMA exit.

The state is reported as a two-bit code: 0 for idle, 1 for busy (READ, CRYPT and WRITE), and 2 for done.

Top module: `cipher_dma_seq`

## Requirements
- R1: A DMA trigger with chaining mode 6 or 7 is rejected: no read request, and the state code stays 0. Values 0 to 5 (ECB, CBC, OFB, CTR, CFB8, CFB128) are accepted.
- R2: The valid operation modes are 0 (128-bit key, encrypt), 2 (256-bit key, encrypt), 4 (128-bit key, decrypt) and 6 (256-bit key, decrypt). A DMA trigger with any other mode is rejected in the same way as in R1.
- R3: While the datapath go signal is high, dp_key256_o is 1 only for modes 2 and 6, dp_decrypt_o is 1 only for modes 4 and 6, and dp_chain_o equals the chaining mode that was latched at the trigger.
- R4: An accepted DMA trigger raises rd_req_o on the next cycle, with rd_len_o equal to the block count times 16 bytes.
- R5: A trigger with DMA disabled pulses single_go_o for exactly one cycle. It issues no read request and leaves the state code unchanged.
- R6: Read done moves the job to the datapath (dp_go_o high). Datapath done raises wr_req_o, with wr_len_o equal to the read length.
- R7: Write done sets the state code to 2. irq_o rises in the same cycle only if irq_en_i is 1 at completion.
- R8: A cycle with irq_clr_i high, and no completion in that cycle, lowers irq_o.
- R9: After reset the state code is 0 and irq_o is 0. A DMA-exit strobe in the done state returns the state code to 0.
- R10: A read error or a write error returns the state code to 0 without setting done and without raising irq_o.
- R11: While a job is busy, the state code is 1. Triggers are ignored: the transfer length is unchanged, single_go_o does not pulse, and the job continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger strobe |
| dma_en_i | input | 1 | Selects the DMA job (1) or the single-block strobe (0) |
| op_mode_i | input | 3 | Key size and direction |
| chain_mode_i | input | 3 | Chaining mode |
| blk_cnt_i | input | BLK_W | Number of 16-byte blocks |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| dma_exit_i | input | 1 | Leave the done state |
| rd_req_o | output | 1 | Stream read request |
| rd_len_o | output | BLK_W+4 | Read length in bytes |
| rd_done_i | input | 1 | Read finished |
| rd_err_i | input | 1 | Read failed |
| dp_go_o | output | 1 | Datapath go |
| dp_key256_o | output | 1 | 256-bit key select |
| dp_decrypt_o | output | 1 | Decrypt select |
| dp_chain_o | output | 3 | Chaining mode to the datapath |
| dp_done_i | input | 1 | Datapath finished |
| wr_req_o | output | 1 | Stream write request |
| wr_len_o | output | BLK_W+4 | Write length in bytes |
| wr_done_i | input | 1 | Write finished |
| wr_err_i | input | 1 | Write failed |
| single_go_o | output | 1 | Single-block engine strobe |
| state_o | output | 2 | 0 idle, 1 busy, 2 done |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a trigger that arrives in the middle of a job. The same trigger must not restart the job, must not fire the single-block strobe, and must not change the latched length. The job task raises a second trigger, with a different block count, while the read request is outstanding. It then checks that the length is unchanged and that the scoreboard sees exactly one read request and one write request. Error aborts are reached by having the bench's stream responder answer with an error instead of done, once in each stream phase.

// File: rtl/cds_pkg.sv
package cds_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CRYPT,
        S_WRITE,
        S_DONE
    } seq_state_e;

    localparam logic [1:0] ST_IDLE = 2'd0;
    localparam logic [1:0] ST_BUSY = 2'd1;
    localparam logic [1:0] ST_DONE = 2'd2;

    localparam int MODE_W      = 3;
    localparam int CHAIN_W     = 3;
    localparam int CHAIN_COUNT = 6;
    localparam int BYTE_SHIFT  = 4;

    typedef struct packed {
        logic               key256;
        logic               decrypt;
        logic [CHAIN_W-1:0] chain;
    } job_cfg_t;
endpackage

// File: rtl/cds_cfg_decode.sv
module cds_cfg_decode
    import cds_pkg::*;
(
    input  logic [MODE_W-1:0]  op_mode_i,
    input  logic [CHAIN_W-1:0] chain_mode_i,
    output logic               cfg_ok_o,
    output job_cfg_t           cfg_o
);
    logic mode_ok;
    logic chain_ok;

    always_comb begin
        mode_ok      = 1'b1;
        cfg_o.key256 = 1'b0;
        cfg_o.decrypt = 1'b0;
        unique case (op_mode_i)
            3'd0:    begin cfg_o.key256 = 1'b0; cfg_o.decrypt = 1'b0; end
            3'd2:    begin cfg_o.key256 = 1'b1; cfg_o.decrypt = 1'b0; end
            3'd4:    begin cfg_o.key256 = 1'b0; cfg_o.decrypt = 1'b1; end
            3'd6:    begin cfg_o.key256 = 1'b1; cfg_o.decrypt = 1'b1; end
            default: mode_ok = 1'b0;
        endcase
        chain_ok    = (int'(chain_mode_i) < CHAIN_COUNT);
        cfg_o.chain = chain_mode_i;
        cfg_ok_o    = mode_ok && chain_ok;
    end
endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
    import cds_pkg::*;
#(
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             dma_en_i,
    input  logic             cfg_ok_i,
    input  job_cfg_t         cfg_i,
    input  logic [LEN_W-1:0] blk_len_i,
    input  logic             dma_exit_i,
    input  logic             rd_done_i,
    input  logic             rd_err_i,
    input  logic             dp_done_i,
    input  logic             wr_done_i,
    input  logic             wr_err_i,
    output logic [1:0]       state_code_o,
    output logic             rd_req_o,
    output logic             dp_go_o,
    output logic             wr_req_o,
    output logic [LEN_W-1:0] xfer_len_o,
    output job_cfg_t         job_cfg_o,
    output logic             single_go_o,
    output logic             finish_o
);
    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    job_cfg_t         cfg_q;
    logic             single_q;
    logic             can_take;
    logic             take_dma;
    logic             busy;

    assign can_take = (state_q == S_IDLE) || (state_q == S_DONE);
    assign take_dma = can_take && trig_i && dma_en_i && cfg_ok_i;
    assign busy     = (state_q == S_READ) || (state_q == S_CRYPT) || (state_q == S_WRITE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take_dma) state_d = S_READ;
            S_READ:  if (rd_err_i) state_d = S_IDLE;
                     else if (rd_done_i) state_d = S_CRYPT;
            S_CRYPT: if (dp_done_i) state_d = S_WRITE;
            S_WRITE: if (wr_err_i) state_d = S_IDLE;
                     else if (wr_done_i) state_d = S_DONE;
            S_DONE:  if (take_dma) state_d = S_READ;
                     else if (dma_exit_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            cfg_q    <= '0;
            single_q <= 1'b0;
        end else begin
            single_q <= can_take && trig_i && !dma_en_i;
            if (take_dma) begin
                len_q <= blk_len_i;
                cfg_q <= cfg_i;
            end
        end
    end

    always_comb begin
        rd_req_o     = 1'b0;
        dp_go_o      = 1'b0;
        wr_req_o     = 1'b0;
        state_code_o = ST_IDLE;
        unique case (state_q)
            S_IDLE:  state_code_o = ST_IDLE;
            S_READ:  begin rd_req_o = 1'b1; state_code_o = ST_BUSY; end
            S_CRYPT: begin dp_go_o  = 1'b1; state_code_o = ST_BUSY; end
            S_WRITE: begin wr_req_o = 1'b1; state_code_o = ST_BUSY; end
            S_DONE:  state_code_o = ST_DONE;
            default: state_code_o = ST_IDLE;
        endcase
        xfer_len_o  = len_q;
        job_cfg_o   = cfg_q;
        single_go_o = single_q;
        finish_o    = (state_q == S_WRITE) && wr_done_i && !wr_err_i;
    end

    p_busy_ignores_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_i) |=> ($stable(xfer_len_o) && !single_go_o));
    p_reject_bad_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && trig_i && dma_en_i && !cfg_ok_i) |=> (state_code_o == ST_IDLE && !rd_req_o));
    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_done_i && !wr_err_i) |=> (state_code_o == ST_DONE));
    p_read_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_err_i) |=> (state_code_o == ST_IDLE));
    p_exit_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && dma_exit_i && !trig_i) |=> (state_code_o == ST_IDLE));
endmodule

// File: rtl/cds_irq.sv
module cds_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic finish_i,
    input  logic irq_en_i,
    input  logic irq_clr_i,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    irq_q <= 1'b0;
        else if (finish_i && irq_en_i) irq_q <= 1'b1;
        else if (irq_clr_i)            irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !finish_i) |=> !irq_o);
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(finish_i && irq_en_i));
endmodule

// File: rtl/cipher_dma_seq.sv
module cipher_dma_seq
    import cds_pkg::*;
#(
    parameter int BLK_W = 16,
    localparam int LEN_W = BLK_W + BYTE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic               dma_en_i,
    input  logic [MODE_W-1:0]  op_mode_i,
    input  logic [CHAIN_W-1:0] chain_mode_i,
    input  logic [BLK_W-1:0]   blk_cnt_i,
    input  logic               irq_en_i,
    input  logic               irq_clr_i,
    input  logic               dma_exit_i,
    output logic               rd_req_o,
    output logic [LEN_W-1:0]   rd_len_o,
    input  logic               rd_done_i,
    input  logic               rd_err_i,
    output logic               dp_go_o,
    output logic               dp_key256_o,
    output logic               dp_decrypt_o,
    output logic [CHAIN_W-1:0] dp_chain_o,
    input  logic               dp_done_i,
    output logic               wr_req_o,
    output logic [LEN_W-1:0]   wr_len_o,
    input  logic               wr_done_i,
    input  logic               wr_err_i,
    output logic               single_go_o,
    output logic [1:0]         state_o,
    output logic               irq_o
);
    logic             cfg_ok;
    job_cfg_t         cfg_dec;
    job_cfg_t         cfg_job;
    logic [LEN_W-1:0] blk_len;
    logic [LEN_W-1:0] xfer_len;
    logic             finish;

    assign blk_len = {blk_cnt_i, {BYTE_SHIFT{1'b0}}};

    cds_cfg_decode u_dec (
        .op_mode_i    (op_mode_i),
        .chain_mode_i (chain_mode_i),
        .cfg_ok_o     (cfg_ok),
        .cfg_o        (cfg_dec)
    );

    cds_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .dma_en_i     (dma_en_i),
        .cfg_ok_i     (cfg_ok),
        .cfg_i        (cfg_dec),
        .blk_len_i    (blk_len),
        .dma_exit_i   (dma_exit_i),
        .rd_done_i    (rd_done_i),
        .rd_err_i     (rd_err_i),
        .dp_done_i    (dp_done_i),
        .wr_done_i    (wr_done_i),
        .wr_err_i     (wr_err_i),
        .state_code_o (state_o),
        .rd_req_o     (rd_req_o),
        .dp_go_o      (dp_go_o),
        .wr_req_o     (wr_req_o),
        .xfer_len_o   (xfer_len),
        .job_cfg_o    (cfg_job),
        .single_go_o  (single_go_o),
        .finish_o     (finish)
    );

    cds_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish_i  (finish),
        .irq_en_i  (irq_en_i),
        .irq_clr_i (irq_clr_i),
        .irq_o     (irq_o)
    );

    assign rd_len_o     = xfer_len;
    assign wr_len_o     = xfer_len;
    assign dp_key256_o  = cfg_job.key256;
    assign dp_decrypt_o = cfg_job.decrypt;
    assign dp_chain_o   = cfg_job.chain;

    p_read_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |-> (rd_len_o == LEN_W'({$past(blk_cnt_i), 4'b0000})));
endmodule

// File: tb/cipher_dma_seq_bench.sv
module cipher_dma_seq_bench;
    localparam int BLK_W = 16;
    localparam int LEN_W = BLK_W + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 0, dma_en = 0, irq_en = 0, irq_clr = 0, dma_exit = 0;
    logic [2:0] op_mode = 0, chain = 0;
    logic [BLK_W-1:0] blk = 0;
    logic rd_done = 0, rd_err = 0, dp_done = 0, wr_done = 0, wr_err = 0;
    logic rd_req, dp_go, wr_req, single_go, irq, key256, decrypt;
    logic [2:0] dp_chain;
    logic [LEN_W-1:0] rd_len, wr_len;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int    q_kind[$];
    int    q_val[$];
    string q_req[$];

    always #10 clk = ~clk;

    cipher_dma_seq #(.BLK_W(BLK_W)) u_cipher_dma_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .dma_en_i(dma_en),
        .op_mode_i(op_mode), .chain_mode_i(chain), .blk_cnt_i(blk),
        .irq_en_i(irq_en), .irq_clr_i(irq_clr), .dma_exit_i(dma_exit),
        .rd_req_o(rd_req), .rd_len_o(rd_len), .rd_done_i(rd_done), .rd_err_i(rd_err),
        .dp_go_o(dp_go), .dp_key256_o(key256), .dp_decrypt_o(decrypt),
        .dp_chain_o(dp_chain), .dp_done_i(dp_done),
        .wr_req_o(wr_req), .wr_len_o(wr_len), .wr_done_i(wr_done), .wr_err_i(wr_err),
        .single_go_o(single_go), .state_o(state), .irq_o(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int val, input string req);
        q_kind.push_back(kind);
        q_val.push_back(val);
        q_req.push_back(req);
    endtask

    // Monitor: event kinds 1 read request, 2 write request, 3 done (value irq), 4 single strobe
    logic prev_rd = 0, prev_wr = 0;
    logic [1:0] prev_st = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && !prev_rd) compare_ev(1, int'(rd_len));
            if (wr_req && !prev_wr) compare_ev(2, int'(wr_len));
            if (state == 2'd2 && prev_st != 2'd2) compare_ev(3, int'(irq));
            if (single_go) compare_ev(4, 0);
        end
        prev_rd = rd_req;
        prev_wr = wr_req;
        prev_st = state;
    end

    task automatic compare_ev(input int kind, input int val);
        if (q_kind.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R11: actual=unexpected event %0d value %0d expected=none", kind, val);
        end else begin
            int ek = q_kind.pop_front();
            int ev = q_val.pop_front();
            string er = q_req.pop_front();
            check({er, " event kind"}, kind, ek);
            check({er, " event value"}, val, ev);
        end
    endtask

    task automatic run_job(input logic [2:0] op, input logic [2:0] ch, input int n,
                           input bit ien, input bit busy_trig, input int err);
        expect_ev(1, n * 16, "R4");
        if (err != 1) expect_ev(2, n * 16, "R6");
        if (err == 0) expect_ev(3, int'(ien), "R7");
        @(negedge clk);
        op_mode = op; chain = ch; blk = BLK_W'(n); irq_en = ien; dma_en = 1; trig = 1;
        @(negedge clk);
        trig = 0;
        check("R11 busy code", int'(state), 1);
        if (busy_trig) begin
            trig = 1; blk = BLK_W'(n + 5);
            @(negedge clk);
            trig = 0;
            check("R11 length kept", int'(rd_len), n * 16);
            check("R11 still reading", int'(rd_req), 1);
        end
        if (err == 1) begin
            rd_err = 1;
            @(negedge clk);
            rd_err = 0;
            check("R10 read abort state", int'(state), 0);
            check("R10 read abort irq", int'(irq), 0);
            return;
        end
        rd_done = 1;
        @(negedge clk);
        rd_done = 0;
        check("R6 datapath go", int'(dp_go), 1);
        check("R3 key256", int'(key256), int'(op[1]));
        check("R3 decrypt", int'(decrypt), int'(op[2]));
        check("R3 chain", int'(dp_chain), int'(ch));
        dp_done = 1;
        @(negedge clk);
        dp_done = 0;
        check("R6 write request", int'(wr_req), 1);
        if (err == 2) begin
            wr_err = 1;
            @(negedge clk);
            wr_err = 0;
            check("R10 write abort state", int'(state), 0);
            check("R10 write abort irq", int'(irq), 0);
            return;
        end
        wr_done = 1;
        @(negedge clk);
        wr_done = 0;
        check("R7 done code", int'(state), 2);
        check("R7 irq", int'(irq), int'(ien));
    endtask

    task automatic try_reject(input logic [2:0] op, input logic [2:0] ch, input string req);
        @(negedge clk);
        op_mode = op; chain = ch; blk = 4; dma_en = 1; trig = 1;
        @(negedge clk);
        trig = 0;
        check({req, " no read"}, int'(rd_req), 0);
        check({req, " idle"}, int'(state), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", int'(state), 0);
        check("R9 reset irq", int'(irq), 0);
        rst_n = 1;
        @(negedge clk);

        run_job(3'd0, 3'd1, 3, 1'b1, 1'b0, 0);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        check("R8 irq cleared", int'(irq), 0);
        dma_exit = 1;
        @(negedge clk); dma_exit = 0;
        check("R9 exit to idle", int'(state), 0);

        run_job(3'd6, 3'd5, 1, 1'b0, 1'b1, 0);
        run_job(3'd2, 3'd2, 7, 1'b1, 1'b0, 0);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        run_job(3'd4, 3'd3, 16'hFFFF, 1'b1, 1'b0, 0);
        @(negedge clk); irq_clr = 1; dma_exit = 1;
        @(negedge clk); irq_clr = 0; dma_exit = 0;

        try_reject(3'd0, 3'd6, "R1 chain 6");
        try_reject(3'd2, 3'd7, "R1 chain 7");
        try_reject(3'd1, 3'd0, "R2 mode 1");
        try_reject(3'd7, 3'd4, "R2 mode 7");

        expect_ev(4, 0, "R5");
        @(negedge clk);
        dma_en = 0; op_mode = 0; chain = 0; trig = 1;
        @(negedge clk);
        trig = 0;
        check("R5 no read", int'(rd_req), 0);
        check("R5 state kept", int'(state), 0);
        @(negedge clk);
        check("R5 one pulse", int'(single_go), 0);

        run_job(3'd0, 3'd4, 2, 1'b1, 1'b0, 1);
        run_job(3'd6, 3'd0, 5, 1'b1, 1'b0, 2);

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", q_kind.size(), 0);
        finish_run();
    end
endmodule